// File: doc/BRIEF.md
# Trimmed-Mean Phase Current Filter

This block conditions the three phase-current readings of a motor inverter when the converter runs freely and is not locked to the PWM carrier. Conversions arrive one at a time, each tagged with the phase it belongs to. Within one PWM period the block collects every reading of each phase into a window. When the period strobe arrives, each window is sorted. A quarter of the readings are removed from each end, and the rest are averaged. Switching spikes and ringing therefore drop out of the result, and no ADC trigger is needed.

Each channel also reports a ripple figure: the second-highest reading of the period minus the second-lowest. A controller downstream can use this ripple to estimate how phase current changes over a carrier cycle. It is more robust than the plain maximum minus minimum, because a single outlier at either end does not move it. A second buffer keeps collecting while the sort and divide run, so a reading at the boundary between periods is never lost.

Top module: `tmf_phase_filter`

## Requirements
- R1: While reset is held, and after it is released, `mean_valid` is 0, every `mean_flat` and `ripple_flat` field is 0, and every window is empty.
- R2: A sample with `smp_valid` high and tag `smp_chan` = c (0, 1 or 2) joins the window of channel c. Field c of the outputs occupies bits [c*DW +: DW]. A sample tagged 3 is ignored by every channel.
- R3: An accepted strobe closes all windows at once. A sample presented in the same cycle as that strobe is counted in the next window.
- R4: For a window of n samples sorted ascending, floor(n/4) samples are dropped from each end. The mean output is the sum of the rest divided by n - 2*floor(n/4), rounded toward zero. For n below 4, nothing is dropped.
- R5: For n of 3 or more, the ripple output is the second-largest sample minus the second-smallest. For n below 3 it is 0.
- R6: An empty window (n = 0) still produces a result, with mean 0 and ripple 0.
- R7: A window holds at most DEPTH samples. The first DEPTH samples of a period are kept, and later ones in that period are dropped.
- R8: Each `mean_valid` bit is a one-cycle pulse marking a new result on its channel. All three channels pulse together, and the outputs hold their value until the next pulse.
- R9: A strobe that arrives while a result is still being computed is ignored. The open windows stay open and keep their contents.
- R10: Samples that arrive while the previous windows are being processed are collected into the next windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A conversion result is present this cycle |
| smp_chan | input | CHW (2) | Phase tag of the present sample |
| smp_data | input | DW (12) | Unsigned conversion result |
| pwm_strobe | input | 1 | End-of-period pulse from the PWM timer |
| mean_valid | output | NCH (3) | One-cycle result pulse per channel |
| mean_flat | output | NCH*DW (36) | Trimmed mean per channel |
| ripple_flat | output | NCH*DW (36) | Second-highest minus second-lowest per channel |

## Verification
The assertions assume two things about the inputs. Strobes are single-cycle pulses. Any strobe that lands while the engines are busy must be dropped by the design, not queued, so a strobe during processing must leave each window count unchanged unless a sample for that channel arrives in the same cycle. The stimulus issues strobes only at known points: after a result has been seen, or on purpose a few cycles into processing. Sample values cover the full range, small ranges with many duplicates, and a mix of only zeros and full-scale readings, so ties and padding-sized values reach the sort.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SORT,
    ENG_SUM,
    ENG_DIV
  } eng_state_t;

  // Samples dropped from each end of a sorted window of n entries.
  function automatic int unsigned trim_of(input int unsigned n);
    return n / 4;
  endfunction

  // Samples left to average after trimming both ends.
  function automatic int unsigned kept_of(input int unsigned n);
    return n - 2 * (n / 4);
  endfunction

endpackage

// File: rtl/tmf_collect.sv
module tmf_collect #(
  parameter int DW    = 12,
  parameter int DEPTH = 16,
  parameter int CHW   = 2,
  parameter int CH_ID = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic [CHW-1:0]             smp_chan,
  input  logic [DW-1:0]              smp_data,
  input  logic                       close_win,
  output logic                       hit,
  output logic [DEPTH*DW-1:0]        win_flat,
  output logic [$clog2(DEPTH+1)-1:0] win_cnt
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH*DW-1:0] buf_q;
  logic [CW-1:0]       cnt_q;
  logic                room;

  assign hit  = smp_valid && (smp_chan == CHW'(CH_ID));
  assign room = (cnt_q < CW'(DEPTH));

  // Sample storage: no reset needed, the engine pads past the count.
  always_ff @(posedge clk) begin
    if (close_win) begin
      if (hit) buf_q[0 +: DW] <= smp_data;
    end else if (hit && room) begin
      buf_q[int'(cnt_q)*DW +: DW] <= smp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (close_win) begin
      cnt_q <= hit ? CW'(1) : CW'(0);
    end else if (hit && room) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign win_flat = buf_q;
  assign win_cnt  = cnt_q;

endmodule

// File: rtl/tmf_oe_stage.sv
module tmf_oe_stage #(
  parameter int DW    = 12,
  parameter int DEPTH = 16
) (
  input  logic                phase,
  input  logic [DEPTH*DW-1:0] din,
  output logic [DEPTH*DW-1:0] dout
);
  // swp[g] exchanges entries g and g+1 on this pass.
  logic [DEPTH-1:0] swp;

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_pair
    assign swp[g] = (phase == 1'(g % 2)) &&
                    (din[g*DW +: DW] > din[(g+1)*DW +: DW]);
  end
  assign swp[DEPTH-1] = 1'b0;

  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    if (k == 0) begin : g_first
      assign dout[k*DW +: DW] = swp[0] ? din[DW +: DW] : din[0 +: DW];
    end else if (k == DEPTH - 1) begin : g_last
      assign dout[k*DW +: DW] = swp[k-1] ? din[(k-1)*DW +: DW] : din[k*DW +: DW];
    end else begin : g_mid
      assign dout[k*DW +: DW] = swp[k-1] ? din[(k-1)*DW +: DW] :
                                swp[k]   ? din[(k+1)*DW +: DW] :
                                           din[k*DW +: DW];
    end
  end

endmodule

// File: rtl/tmf_chan_engine.sv
module tmf_chan_engine #(
  parameter int DW    = 12,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [DEPTH*DW-1:0]        win_flat,
  input  logic [$clog2(DEPTH+1)-1:0] win_cnt,
  output logic                       busy,
  output logic                       res_valid,
  output logic [DW-1:0]              res_mean,
  output logic [DW-1:0]              res_ripple
);
  import tmf_pkg::*;

  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW  = DW + PW;
  localparam int ITW = $clog2(SW);

  eng_state_t          st_q;
  logic [DEPTH*DW-1:0] w_q;
  logic [DEPTH*DW-1:0] w_pass;
  logic [CW-1:0]       cnt_q;
  logic [PW-1:0]       pass_q;
  logic [SW-1:0]       quo_q;
  logic [CW-1:0]       rem_q;
  logic [CW-1:0]       dvs_q;
  logic [ITW-1:0]      it_q;
  logic [DW-1:0]       rip_q;

  tmf_oe_stage #(.DW(DW), .DEPTH(DEPTH)) u_stage (
    .phase (pass_q[0]),
    .din   (w_q),
    .dout  (w_pass)
  );

  // Sum of the entries that survive trimming, and the ripple pick.
  logic [SW-1:0] sum_c;
  logic [DW-1:0] rip_c;
  int unsigned   trim_c;
  int unsigned   kept_c;

  always_comb begin
    trim_c = trim_of(32'(cnt_q));
    kept_c = kept_of(32'(cnt_q));
    sum_c  = '0;
    for (int unsigned i = 0; i < DEPTH; i++) begin
      if (i >= trim_c && i < 32'(cnt_q) - trim_c)
        sum_c = sum_c + SW'(w_q[i*DW +: DW]);
    end
    rip_c = '0;
    if (cnt_q >= CW'(3))
      rip_c = w_q[(int'(cnt_q) - 2)*DW +: DW] - w_q[DW +: DW];
  end

  // One restoring division step per cycle.
  logic [CW:0]   dv_tmp;
  logic [CW:0]   dv_diff;
  logic          dv_ge;
  logic [CW-1:0] rem_n;
  logic [SW-1:0] quo_n;

  always_comb begin
    dv_tmp  = {rem_q, quo_q[SW-1]};
    dv_diff = dv_tmp - {1'b0, dvs_q};
    dv_ge   = (dv_tmp >= {1'b0, dvs_q});
    rem_n   = dv_ge ? dv_diff[CW-1:0] : dv_tmp[CW-1:0];
    quo_n   = {quo_q[SW-2:0], dv_ge};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ENG_IDLE;
      w_q        <= '0;
      cnt_q      <= '0;
      pass_q     <= '0;
      quo_q      <= '0;
      rem_q      <= '0;
      dvs_q      <= '0;
      it_q       <= '0;
      rip_q      <= '0;
      res_valid  <= 1'b0;
      res_mean   <= '0;
      res_ripple <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (st_q)
        ENG_IDLE: begin
          if (start) begin
            for (int i = 0; i < DEPTH; i++)
              w_q[i*DW +: DW] <= (CW'(i) < win_cnt) ? win_flat[i*DW +: DW] : {DW{1'b1}};
            cnt_q  <= win_cnt;
            pass_q <= '0;
            st_q   <= ENG_SORT;
          end
        end
        ENG_SORT: begin
          w_q    <= w_pass;
          pass_q <= pass_q + PW'(1);
          if (pass_q == PW'(DEPTH - 1)) st_q <= ENG_SUM;
        end
        ENG_SUM: begin
          quo_q <= sum_c;
          rem_q <= '0;
          dvs_q <= CW'(kept_c);
          rip_q <= rip_c;
          it_q  <= '0;
          st_q  <= ENG_DIV;
        end
        ENG_DIV: begin
          quo_q <= quo_n;
          rem_q <= rem_n;
          it_q  <= it_q + ITW'(1);
          if (it_q == ITW'(SW - 1)) begin
            res_mean   <= (dvs_q == '0) ? '0 : quo_n[DW-1:0];
            res_ripple <= rip_q;
            res_valid  <= 1'b1;
            st_q       <= ENG_IDLE;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ENG_IDLE);

endmodule

// File: rtl/tmf_phase_filter.sv
module tmf_phase_filter #(
  parameter int DW    = 12,
  parameter int DEPTH = 16,
  parameter int NCH   = 3,
  parameter int CHW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CHW-1:0]    smp_chan,
  input  logic [DW-1:0]     smp_data,
  input  logic              pwm_strobe,
  output logic [NCH-1:0]    mean_valid,
  output logic [NCH*DW-1:0] mean_flat,
  output logic [NCH*DW-1:0] ripple_flat
);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events for the checker.
  logic                accept;
  logic                busy_any;
  logic [NCH-1:0]      busy_vec;
  logic [NCH-1:0]      hit_vec;
  logic [NCH*CW-1:0]   cnt_flat;
  logic [DEPTH*DW-1:0] win_flat [NCH];

  assign busy_any = |busy_vec;
  assign accept   = pwm_strobe && !busy_any;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmf_collect #(.DW(DW), .DEPTH(DEPTH), .CHW(CHW), .CH_ID(c)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_chan  (smp_chan),
      .smp_data  (smp_data),
      .close_win (accept),
      .hit       (hit_vec[c]),
      .win_flat  (win_flat[c]),
      .win_cnt   (cnt_flat[c*CW +: CW])
    );

    tmf_chan_engine #(.DW(DW), .DEPTH(DEPTH)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .win_flat   (win_flat[c]),
      .win_cnt    (cnt_flat[c*CW +: CW]),
      .busy       (busy_vec[c]),
      .res_valid  (mean_valid[c]),
      .res_mean   (mean_flat[c*DW +: DW]),
      .res_ripple (ripple_flat[c*DW +: DW])
    );
  end

endmodule

// File: rtl/tmf_checker.sv
module tmf_checker #(
  parameter int NCH   = 3,
  parameter int DEPTH = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             pwm_strobe,
  input logic                             accept,
  input logic                             busy_any,
  input logic [NCH-1:0]                   hit_vec,
  input logic [NCH*$clog2(DEPTH+1)-1:0]   cnt_flat,
  input logic [NCH-1:0]                   mean_valid
);
  localparam int CW = $clog2(DEPTH + 1);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mean_valid) |-> !busy_any);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_any);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mean_valid[c] |=> !mean_valid[c]);

    // R7
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[c*CW +: CW] <= CW'(DEPTH));

    // R9
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_strobe && busy_any && !hit_vec[c]) |=> $stable(cnt_flat[c*CW +: CW]));

    // R3
    win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit_vec[c]) |=> (cnt_flat[c*CW +: CW] == '0));
  end

endmodule

bind tmf_phase_filter tmf_checker #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_strobe (pwm_strobe),
  .accept     (accept),
  .busy_any   (busy_any),
  .hit_vec    (hit_vec),
  .cnt_flat   (cnt_flat),
  .mean_valid (mean_valid)
);

// File: tb/tmf_phase_filter_bench.sv
module tmf_phase_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int DEPTH = 16;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [1:0]        smp_chan = '0;
  logic [DW-1:0]     smp_data = '0;
  logic              pwm_strobe = 1'b0;
  logic [NCH-1:0]    mean_valid;
  logic [NCH*DW-1:0] mean_flat;
  logic [NCH*DW-1:0] ripple_flat;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmf_phase_filter u_tmf_phase_filter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .pwm_strobe(pwm_strobe), .mean_valid(mean_valid),
    .mean_flat(mean_flat), .ripple_flat(ripple_flat)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int lcg = 32'h1234;

  int cur_n [NCH];
  int cur_v [NCH][DEPTH];
  int win_n [NCH];
  int win_v [NCH][DEPTH];

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'h7fffff;
  endfunction

  // One input cycle; acc tells the model whether the strobe closes windows.
  task automatic tick(input bit sv, input int ch, input int v, input bit st, input bit acc);
    smp_valid = sv; smp_chan = 2'(ch); smp_data = DW'(v); pwm_strobe = st;
    if (st && acc) begin
      for (int c = 0; c < NCH; c++) begin
        win_n[c] = cur_n[c];
        for (int i = 0; i < DEPTH; i++) win_v[c][i] = cur_v[c][i];
        cur_n[c] = 0;
      end
    end
    if (sv && ch < NCH && cur_n[ch] < DEPTH) begin
      cur_v[ch][cur_n[ch]] = v;
      cur_n[ch]++;
    end
    @(negedge clk);
    smp_valid = 1'b0; pwm_strobe = 1'b0;
  endtask

  task automatic expect_of(input int c, output int m, output int r);
    int s [DEPTH];
    int n, t, k, sum;
    n = win_n[c];
    for (int i = 0; i < DEPTH; i++) s[i] = win_v[c][i];
    for (int a = 0; a < n; a++)
      for (int b = 0; b + 1 < n - a; b++)
        if (s[b] > s[b+1]) begin int x = s[b]; s[b] = s[b+1]; s[b+1] = x; end
    t = n / 4;
    k = n - 2 * t;
    sum = 0;
    for (int i = t; i < n - t; i++) sum += s[i];
    m = (k == 0) ? 0 : sum / k;
    r = (n >= 3) ? s[n-2] - s[1] : 0;
  endtask

  task automatic wait_result(input string tag);
    int seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      if (mean_valid != '0) seen = 1;
      else @(negedge clk);
    end
    chk({tag, " R8 all channels pulse"}, int'(mean_valid), 7);
    for (int c = 0; c < NCH; c++) begin
      int m, r;
      expect_of(c, m, r);
      chk({tag, (win_n[c] == 0) ? " R6 mean" : " R4 mean"}, int'(mean_flat[c*DW +: DW]), m);
      chk({tag, (win_n[c] == 0) ? " R6 ripple" : " R5 ripple"}, int'(ripple_flat[c*DW +: DW]), r);
    end
    @(negedge clk);
    chk({tag, " R8 pulse width"}, int'(mean_valid), 0);
    for (int c = 0; c < NCH; c++) begin
      int m, r;
      expect_of(c, m, r);
      chk({tag, " R8 hold"}, int'(mean_flat[c*DW +: DW]), m);
    end
  endtask

  function automatic int pick(input int mode);
    case (mode)
      0: return rnd() & 12'hfff;
      1: return rnd() & 7;
      default: return (rnd() & 1) ? 4095 : 0;
    endcase
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) begin cur_n[c] = 0; win_n[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 outputs during and after reset
    chk("R1 valid in reset", int'(mean_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(mean_valid), 0);
    chk("R1 mean", (mean_flat == '0) ? 0 : 1, 0);
    chk("R1 ripple", (ripple_flat == '0) ? 0 : 1, 0);

    // Sweep window sizes 0..DEPTH with several value patterns (R2 R3 R4 R5 R6)
    for (int n = 0; n <= DEPTH; n++) begin
      int cnt [NCH];
      cnt[0] = n; cnt[1] = DEPTH - n; cnt[2] = (n * 5) % (DEPTH + 1);
      for (int idx = 0; idx < DEPTH; idx++) begin
        for (int c = 0; c < NCH; c++)
          if (idx < cnt[c]) tick(1, c, pick(n % 3), 0, 0);
        if (idx % 4 == 1) tick(1, 3, 4000, 0, 0); // R2 tag 3 ignored
      end
      // R3 odd n: a sample arrives with the strobe and belongs to the next window
      tick(n % 2 == 1, 1, pick(0), 1, 1);
      wait_result("sweep");
    end

    // R7 overflow: twenty samples into channel 0
    for (int i = 0; i < 20; i++) tick(1, 0, (i < DEPTH) ? i * 10 : 4095, 0, 0);
    tick(1, 2, 77, 0, 0);
    tick(0, 0, 0, 1, 1);
    wait_result("R7 overflow");

    // R9 R10: strobe while busy is ignored, samples during busy go to next window
    for (int i = 0; i < 6; i++) tick(1, i % 3, pick(0), 0, 0);
    tick(0, 0, 0, 1, 1);
    tick(1, 0, 1000, 0, 0);
    tick(1, 0, 3000, 0, 0);
    tick(1, 2, 55, 0, 0);
    tick(0, 0, 0, 1, 0);
    tick(1, 0, 2000, 0, 0);
    wait_result("R10 first");
    tick(1, 1, 9, 0, 0);
    tick(0, 0, 0, 1, 1);
    wait_result("R9 R10 second");
    chk("R9 kept window size", win_n[0], 3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule